// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is a byte-wide, register-mapped SMBus master. Software fills the slave address, command and data registers, then writes a transaction code into the control register with the start bit set. The engine then runs one complete transaction on the two-wire bus: quick, send/receive byte, write/read byte-data or write/read word-data. Reads of byte-data and word-data registers use a write phase for the command followed by a repeated START.

The block drives SCL and SDA as open-drain pulls: an output high means "pull the line low". It samples SDA back from the bus. Each bit lasts four quarter-phases, and `QTR_CYC` clock cycles make up one quarter. The outcome is reported in sticky status flags that software clears by writing ones. A kill bit in the control register aborts a running transfer.

Top module: `smb_host_ctl`

## Requirements
- R1: After reset every register reads zero and neither bus line is pulled. Register offsets: 0 status, 2 control, 3 command, 4 address, 5 data0, 6 data1. Every other offset reads zero.
- R2: Control code 0x00 (bits 4:2 of control) runs a quick transaction. The engine sends START, the address register byte and STOP. When the slave acknowledges, only the completed flag (status bit 0x02) is set.
- R3: Code 0x08 runs byte-data. A write sends the address with bit 0 clear, then command, then data0. A read sends the address with bit 0 clear and the command, then a repeated START, the address with bit 0 set, and receives one byte into data0 with a closing not-acknowledge.
- R4: Code 0x0C runs word-data. A write sends data0 then data1. A read returns the first received byte (low) in data0 and the second (high) in data1.
- R5: Code 0x04 runs send/receive byte. The address register holds the 7-bit slave address in bits 7:1 and the direction in bit 0, where 1 means read. A write sends the command register byte. A read receives one byte into data0.
- R6: A missing acknowledge on the address or on a written byte ends the transfer with STOP. It sets device error (status 0x04) and does not set completed, and both lines are left released.
- R7: Reading SDA low while the engine releases it for a sent data bit sets bus error (status 0x08). The engine releases both lines at once and ends without completed.
- R8: Control bit 0x02 (kill) set during a transfer clears host busy (status 0x01) on the next cycle, sets failed (status 0x10) and releases both lines.
- R9: A start request (control bit 0x40) written while host busy is set is ignored. The transaction code field also keeps its value.
- R10: Status bits 0x10, 0x08, 0x04 and 0x02 are cleared only by writing a one to their own position. Written zeros leave them unchanged.
- R11: A start with a code that has bit 0x10 set (such as block, 0x14) sets failed at once, never raises host busy and never pulls SCL.
- R12: When hardware sets a status flag in the same cycle that software writes a one to clear it, the flag ends up set.
- R13: Host busy reads one in the cycle after the start write. The start bit itself is not stored and reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The completed flag is set by the engine as STOP finishes, and a software write-one-to-clear to the same flag can land on that same edge. The bench provokes this by writing 0x02 to status on every cycle in which it still sees host busy. The last such write therefore lands on the very edge where busy falls and completed rises. The scoreboard monitor samples status right after that edge and expects completed to be set, and the bench reads it again once the writes stop.

// File: rtl/smb_host_ctl.sv
module smb_host_ctl #(
  parameter int QTR_CYC = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in
);

  localparam int DW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [1:0] OP_RS = 2'd0, OP_TX = 2'd1, OP_RX = 2'd2, OP_END = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_t;

  st_t        st;
  logic [1:0] qtr;
  logic [DW-1:0] div_cnt;
  logic [3:0] bit_n;
  logic [2:0] step;
  logic [7:0] tx_sh, rx_sh;
  logic       rx_mode, ack_n, txn_err;
  logic [1:0] rx_arg;
  logic [2:0] cmd3;
  logic       pec, kill;
  logic [7:0] adr, cmdr, d0, d1;
  logic       f_fail, f_bus, f_dev, f_done;

  function automatic logic [4:0] plan_item(input logic [1:0] kind, input logic rd, input logic [2:0] s);
    logic [4:0] it;
    it = {OP_END, 3'd0};
    case (kind)
      2'd0: if (s == 3'd1) it = {OP_TX, 3'd0};
      2'd1: case (s)
              3'd1: it = {OP_TX, 3'd0};
              3'd2: it = rd ? {OP_RX, 3'd0} : {OP_TX, 3'd3};
              default: it = {OP_END, 3'd0};
            endcase
      2'd2: case (s)
              3'd1: it = {OP_TX, 3'd1};
              3'd2: it = {OP_TX, 3'd3};
              3'd3: it = rd ? {OP_RS, 3'd0} : {OP_TX, 3'd4};
              3'd4: it = rd ? {OP_TX, 3'd2} : {OP_END, 3'd0};
              3'd5: it = {OP_RX, 3'd0};
              default: it = {OP_END, 3'd0};
            endcase
      default: case (s)
              3'd1: it = {OP_TX, 3'd1};
              3'd2: it = {OP_TX, 3'd3};
              3'd3: it = rd ? {OP_RS, 3'd0} : {OP_TX, 3'd4};
              3'd4: it = rd ? {OP_TX, 3'd2} : {OP_TX, 3'd5};
              3'd5: it = rd ? {OP_RX, 3'd1} : {OP_END, 3'd0};
              3'd6: it = {OP_RX, 3'd2};
              default: it = {OP_END, 3'd0};
            endcase
    endcase
    return it;
  endfunction

  logic [4:0] nxt;
  logic [7:0] tx_pick;
  assign nxt = plan_item(cmd3[1:0], adr[0], 3'(step + 3'd1));

  always_comb begin
    case (nxt[2:0])
      3'd0:    tx_pick = adr;
      3'd1:    tx_pick = {adr[7:1], 1'b0};
      3'd2:    tx_pick = {adr[7:1], 1'b1};
      3'd3:    tx_pick = cmdr;
      3'd4:    tx_pick = d0;
      default: tx_pick = d1;
    endcase
  end

  logic busy, tick, qend, wr_sts, wr_ctl, start_req, go, bad, do_kill;
  logic arb_lost, byte_end, nack_end, rx_store, stop_end, disp;

  assign busy      = (st != ST_IDLE);
  assign tick      = busy && (div_cnt == DW'(QTR_CYC - 1));
  assign qend      = tick && (qtr == 2'd3);
  assign wr_sts    = reg_wr && (reg_addr == 4'd0);
  assign wr_ctl    = reg_wr && (reg_addr == 4'd2);
  assign start_req = wr_ctl && reg_wdata[6] && !reg_wdata[1] && !busy;
  assign go        = start_req && !reg_wdata[4];
  assign bad       = start_req && reg_wdata[4];
  assign do_kill   = kill && busy;
  assign arb_lost  = tick && (st == ST_BIT) && !rx_mode && (bit_n != 4'd8) && (qtr == 2'd2)
                     && tx_sh[7] && !sda_in && !do_kill;
  assign byte_end  = qend && (st == ST_BIT) && (bit_n == 4'd8);
  assign nack_end  = byte_end && !rx_mode && ack_n && !do_kill;
  assign rx_store  = byte_end && rx_mode && !do_kill;
  assign stop_end  = qend && (st == ST_STOP) && !do_kill;
  assign disp      = qend && ((st == ST_START) || (byte_end && !(!rx_mode && ack_n)));

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || tick) div_cnt <= '0;
    else                         div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; qtr <= '0; step <= '0; bit_n <= '0;
      tx_sh <= '0; rx_sh <= '0; rx_mode <= 1'b0; rx_arg <= '0;
      ack_n <= 1'b0; txn_err <= 1'b0;
    end else if (do_kill) begin
      st <= ST_IDLE;
    end else if (go) begin
      st <= ST_START; qtr <= '0; step <= '0; txn_err <= 1'b0;
    end else if (arb_lost) begin
      st <= ST_IDLE;
    end else if (tick) begin
      qtr <= qtr + 2'd1;
      if (st == ST_BIT && qtr == 2'd2) begin
        if (bit_n != 4'd8) rx_sh <= {rx_sh[6:0], sda_in};
        else               ack_n <= sda_in;
      end
      if (st == ST_BIT && qtr == 2'd3 && bit_n != 4'd8) begin
        bit_n <= bit_n + 4'd1;
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
      if (nack_end) begin
        st <= ST_STOP; txn_err <= 1'b1;
      end else if (disp) begin
        step <= 3'(step + 3'd1);
        bit_n <= '0;
        case (nxt[4:3])
          OP_RS:   st <= ST_START;
          OP_TX:   begin st <= ST_BIT; rx_mode <= 1'b0; tx_sh <= tx_pick; end
          OP_RX:   begin st <= ST_BIT; rx_mode <= 1'b1; rx_arg <= nxt[1:0]; end
          default: st <= ST_STOP;
        endcase
      end else if (stop_end) begin
        st <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd3 <= '0; pec <= 1'b0; kill <= 1'b0; adr <= '0; cmdr <= '0; d0 <= '0; d1 <= '0;
      f_fail <= 1'b0; f_bus <= 1'b0; f_dev <= 1'b0; f_done <= 1'b0;
    end else begin
      f_fail <= (do_kill || bad)              || (f_fail && !(wr_sts && reg_wdata[4]));
      f_bus  <= arb_lost                      || (f_bus  && !(wr_sts && reg_wdata[3]));
      f_dev  <= nack_end                      || (f_dev  && !(wr_sts && reg_wdata[2]));
      f_done <= (stop_end && !txn_err)        || (f_done && !(wr_sts && reg_wdata[1]));
      if (wr_ctl) begin
        kill <= reg_wdata[1];
        if (!busy) begin cmd3 <= reg_wdata[4:2]; pec <= reg_wdata[7]; end
      end
      if (reg_wr && reg_addr == 4'd3) cmdr <= reg_wdata;
      if (reg_wr && reg_addr == 4'd4) adr  <= reg_wdata;
      if (rx_store && rx_arg != 2'd2)  d0 <= rx_sh;
      else if (reg_wr && reg_addr == 4'd5) d0 <= reg_wdata;
      if (rx_store && rx_arg == 2'd2)  d1 <= rx_sh;
      else if (reg_wr && reg_addr == 4'd6) d1 <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {3'b000, f_fail, f_bus, f_dev, f_done, busy};
      4'd2:    reg_rdata = {pec, 2'b00, cmd3, kill, 1'b0};
      4'd3:    reg_rdata = cmdr;
      4'd4:    reg_rdata = adr;
      4'd5:    reg_rdata = d0;
      4'd6:    reg_rdata = d1;
      default: reg_rdata = 8'h00;
    endcase
  end

  logic dv;
  assign dv = rx_mode ? ((bit_n == 4'd8) ? (rx_arg != 2'd1) : 1'b1)
                      : ((bit_n == 4'd8) ? 1'b1 : tx_sh[7]);

  always_comb begin
    case (st)
      ST_START: begin scl_low = (qtr == 2'd0) || (qtr == 2'd3); sda_low = qtr[1]; end
      ST_BIT:   begin scl_low = !qtr[1];       sda_low = !dv;    end
      ST_STOP:  begin scl_low = (qtr == 2'd0); sda_low = !qtr[1]; end
      default:  begin scl_low = 1'b0;          sda_low = 1'b0;   end
    endcase
  end

  assert_busy_after_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (st == ST_START));
  assert_kill_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_kill |=> (!busy && f_fail));
  assert_zero_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !reg_wdata[2] && f_dev) |=> f_dev);
  assert_nack_goes_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_dev) |-> (st == ST_STOP));
  assert_arb_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_bus) |-> (!busy && !scl_low && !sda_low));
  assert_code_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl) |=> $stable(cmd3));

endmodule

// File: tb/smb_host_ctl_tb_top.sv
module smb_host_ctl_tb_top;
  localparam int QC = 4;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic dut_scl_low, dut_sda_low;
  logic slv_low = 1'b0;
  logic jam = 1'b0;
  logic scl_bus, sda_bus;

  always #10 clk = ~clk;

  assign scl_bus = !dut_scl_low;
  assign sda_bus = !(dut_sda_low || slv_low || jam);

  smb_host_ctl #(.QTR_CYC(QC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_low(dut_scl_low), .sda_low(dut_sda_low), .sda_in(sda_bus)
  );

  // slave device model
  logic [7:0] mem [0:15];
  logic [3:0] ptr = 4'd0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, active = 1'b0, started = 1'b0;
  logic [3:0] rcnt = 4'd0;
  logic [7:0] shr = 8'h00, txb = 8'h00;
  logic rdmode = 1'b0, matched = 1'b0, mack = 1'b0, rd_first = 1'b0;
  logic [1:0] bidx = 2'd0;
  int scl_pulls = 0;

  always @(posedge clk) begin
    prev_scl <= scl_bus;
    prev_sda <= sda_bus;
    if (dut_scl_low) scl_pulls <= scl_pulls + 1;
    if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
      active <= 1'b1; rcnt <= 4'd0; started <= 1'b0; rdmode <= 1'b0; bidx <= 2'd0; slv_low <= 1'b0;
    end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
      active <= 1'b0; slv_low <= 1'b0;
    end else if (active && !prev_scl && scl_bus) begin
      started <= 1'b1;
      if (rcnt < 4'd8) shr <= {shr[6:0], sda_bus};
      else mack <= !sda_bus;
      rcnt <= (rcnt == 4'd8) ? 4'd0 : rcnt + 4'd1;
    end else if (active && prev_scl && !scl_bus) begin
      if (rcnt == 4'd8) begin
        if (rdmode) slv_low <= 1'b0;
        else if (bidx == 2'd0) begin
          matched  <= (shr[7:1] == SLV);
          rdmode   <= (shr[7:1] == SLV) && shr[0];
          rd_first <= 1'b1;
          slv_low  <= (shr[7:1] == SLV);
          bidx <= 2'd1;
        end else if (matched) begin
          slv_low <= 1'b1;
          if (bidx == 2'd1) ptr <= shr[3:0];
          else begin mem[ptr] <= shr; ptr <= ptr + 4'd1; end
          bidx <= 2'd2;
        end else slv_low <= 1'b0;
      end else if (rcnt == 4'd0 && started) begin
        if (rdmode && (rd_first || mack)) begin
          txb <= mem[ptr]; slv_low <= !mem[ptr][7]; ptr <= ptr + 4'd1; rd_first <= 1'b0;
        end else slv_low <= 1'b0;
      end else if (rdmode) begin
        slv_low <= !txb[7 - rcnt];
      end
    end
  end

  // checking
  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;
  logic [7:0] exp_q [$];
  logic mon_busy = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (reg_addr == 4'd0) begin
      if (mon_busy && !reg_rdata[0]) begin
        m_chk++;
        if (exp_q.size() == 0) begin
          m_bad++;
          $display("FAIL scoreboard: unexpected end, status actual=%h expected=none", reg_rdata);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (reg_rdata !== e) begin
            m_bad++;
            $display("FAIL scoreboard status actual=%h expected=%h", reg_rdata, e);
          end
        end
      end
      mon_busy <= reg_rdata[0];
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 4'd0;
  endtask

  task automatic start_txn(input logic [7:0] ctl, input logic [7:0] exp_sts);
    logic [7:0] s;
    wr(4'd0, 8'h1E);
    exp_q.push_back(exp_sts);
    wr(4'd2, ctl | 8'h40);
    #1 s = reg_rdata;
    chk("R13 busy one cycle after start", s & 8'h01, 8'h01);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      reg_addr = 4'd0;
      #1 if (!reg_rdata[0]) return;
    end
    chk("wait_idle timeout", 8'h01, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk + m_chk, n_bad + m_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int pulls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1 status", v, 8'h00);
    rd(4'd2, v); chk("R1 control", v, 8'h00);
    rd(4'd5, v); chk("R1 data0", v, 8'h00);
    chk("R1 lines released", {6'd0, dut_scl_low, dut_sda_low}, 8'h00);

    // R2 quick to present slave
    wr(4'd4, {SLV, 1'b0});
    start_txn(8'h00, 8'h02); wait_idle();
    rd(4'd0, v); chk("R2 quick status", v, 8'h02);
    rd(4'd2, v); chk("R13 start bit not stored", v, 8'h00);

    // R3 byte-data write then read
    wr(4'd3, 8'h03); wr(4'd5, 8'hA5);
    start_txn(8'h08, 8'h02); wait_idle();
    wr(4'd5, 8'h00); wr(4'd4, {SLV, 1'b1});
    start_txn(8'h08, 8'h02); wait_idle();
    rd(4'd5, v); chk("R3 byte-data read data0", v, 8'hA5);

    // R4 word-data write then read
    wr(4'd4, {SLV, 1'b0}); wr(4'd3, 8'h05); wr(4'd5, 8'h34); wr(4'd6, 8'h12);
    start_txn(8'h0C, 8'h02); wait_idle();
    wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd4, {SLV, 1'b1});
    start_txn(8'h0C, 8'h02); wait_idle();
    rd(4'd5, v); chk("R4 word low in data0", v, 8'h34);
    rd(4'd6, v); chk("R4 word high in data1", v, 8'h12);

    // R5 send byte sets pointer, receive byte reads it
    wr(4'd4, {SLV, 1'b0}); wr(4'd3, 8'h07); wr(4'd5, 8'h6C);
    start_txn(8'h08, 8'h02); wait_idle();
    start_txn(8'h04, 8'h02); wait_idle();
    wr(4'd5, 8'h00); wr(4'd4, {SLV, 1'b1});
    start_txn(8'h04, 8'h02); wait_idle();
    rd(4'd5, v); chk("R5 receive byte data0", v, 8'h6C);

    // R6 no acknowledge
    wr(4'd4, 8'h42);
    start_txn(8'h00, 8'h04); wait_idle();
    rd(4'd0, v); chk("R6 device error, no completed", v, 8'h04);
    chk("R6 lines released", {6'd0, dut_scl_low, dut_sda_low}, 8'h00);

    // R10 write-one-to-clear
    wr(4'd0, 8'h00); rd(4'd0, v); chk("R10 zero write keeps flag", v, 8'h04);
    wr(4'd0, 8'h12); rd(4'd0, v); chk("R10 other bits keep flag", v, 8'h04);
    wr(4'd0, 8'h04); rd(4'd0, v); chk("R10 one clears flag", v, 8'h00);

    // R7 lost arbitration
    wr(4'd4, {SLV, 1'b0});
    start_txn(8'h00, 8'h08);
    jam = 1'b1;
    wait_idle();
    chk("R7 lines released", {6'd0, dut_scl_low, dut_sda_low}, 8'h00);
    jam = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd0, v); chk("R7 bus error, no completed", v, 8'h08);

    // R8 kill
    wr(4'd3, 8'h09);
    start_txn(8'h0C, 8'h10);
    repeat (40) @(negedge clk);
    wr(4'd2, 8'h0E);
    @(negedge clk);
    #1 chk("R8 busy cleared, failed set", reg_rdata, 8'h10);
    chk("R8 lines released", {6'd0, dut_scl_low, dut_sda_low}, 8'h00);
    wr(4'd2, 8'h0C);

    // R9 start while busy
    wr(4'd3, 8'h09); wr(4'd5, 8'h11); wr(4'd6, 8'h22);
    start_txn(8'h0C, 8'h02);
    repeat (30) @(negedge clk);
    wr(4'd2, 8'h44);
    wait_idle();
    rd(4'd2, v); chk("R9 code field unchanged", v, 8'h0C);
    repeat (64) @(negedge clk);
    rd(4'd0, v); chk("R9 no second transfer", v, 8'h02);
    wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd4, {SLV, 1'b1});
    start_txn(8'h0C, 8'h02); wait_idle();
    rd(4'd6, v); chk("R9 original transfer ran", v, 8'h22);

    // R11 unsupported code
    wr(4'd0, 8'h1E);
    pulls = scl_pulls;
    wr(4'd2, 8'h54);
    repeat (20) @(negedge clk);
    rd(4'd0, v); chk("R11 failed, never busy", v, 8'h10);
    chk("R11 no SCL activity", (scl_pulls == pulls) ? 8'h01 : 8'h00, 8'h01);
    wr(4'd2, 8'h00);

    // R12 clear and set in the same cycle
    wr(4'd4, {SLV, 1'b0});
    start_txn(8'h00, 8'h02);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      reg_addr = 4'd0;
      #1 if (!reg_rdata[0]) begin reg_wr = 1'b0; break; end
      reg_wdata = 8'h02; reg_wr = 1'b1;
    end
    reg_wr = 1'b0;
    rd(4'd0, v); chk("R12 set wins over clear", v, 8'h02);

    repeat (10) @(negedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end
endmodule